// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Level Signalling

This block sits between a host or DMA engine and an audio frame serializer. It holds two independent FIFOs of 32-bit words. The playback FIFO is filled by the host and drained by the serializer. The capture FIFO is filled by the serializer and drained by the host. From the fill level of each FIFO it raises DMA request and panic outputs against four programmable 8-bit levels. It also computes need-service flags from a two-bit quarter-depth selector, keeps sticky underflow and overflow error flags, and gives a masked interrupt vector.

Both FIFOs and all flags run in the system clock domain. Two kinds of command are routed through the slower audio bit-clock domain so that software sees them act in step with the audio side. The first is a per-direction flush. The second is a software handshake bit whose echo follows it. Each command passes two bit-clock flops and then two system-clock flops before it takes effect or becomes visible. A flush is therefore never applied before at least two bit-clock edges have passed.

Top module: `pcm_fifo_dma`

## Requirements
- R1: After reset both FIFOs are empty, both error flags are 0, all DMA outputs are 0 and `sync_echo` is 0.
- R2: Each FIFO is DEPTH (64) words deep and first-in first-out. The head word is always shown on `ser_tx_data` and `host_rdata`. A write into a full FIFO is dropped, and a read from an empty FIFO changes nothing.
- R3: While `blk_en` is 0, host writes, host reads, serializer pops and serializer pushes are all ignored, and every DMA output is 0.
- R4: Serializer pops take effect only while `tx_run` is 1. Serializer pushes take effect only while `rx_run` is 1.
- R5: `dma_tx_req` is `dma_en & blk_en & (playback fill < dma_levels[15:8])`. `dma_tx_panic` is the same expression with `dma_levels[31:24]`.
- R6: `dma_rx_req` is `dma_en & blk_en & (capture fill > dma_levels[7:0])`. `dma_rx_panic` is the same expression with `dma_levels[23:16]`.
- R7: With Q = DEPTH/4, `tx_need` is 1 when playback fill <= `tx_need_sel`*Q. `rx_need` is 1 when capture fill > `rx_need_sel`*Q.
- R8: `tx_empty` is 1 when playback fill is 0. `rx_has_data` is 1 when capture fill is non-zero. `rx_full` is 1 when capture fill equals DEPTH.
- R9: A serializer pop that is enabled and hits an empty playback FIFO sets `tx_err`. A serializer push that is enabled and hits a full capture FIFO sets `rx_err`. Each flag holds until its clear pulse (`err_clr_tx`, `err_clr_rx`). A new error in the same cycle as its clear pulse wins over the clear.
- R10: `irq_status` bit 0 is `tx_need`, bit 1 is `rx_need`, bit 2 is `tx_err` and bit 3 is `rx_err`, each ANDed with the same bit of `irq_en`. `irq` is the OR of `irq_status`.
- R11: A one-cycle pulse on `tx_clr` or `rx_clr` empties that FIFO only after two bit-clock edges and two further system-clock edges. The FIFO is still intact three system-clock cycles after the pulse when the bit clock is eight times slower.
- R12: `sync_echo` follows a change of `sync_tgl` only after it has crossed two bit-clock flops and two system-clock flops. It is unchanged three system-clock cycles after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| bclk | input | 1 | Audio bit clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| blk_en | input | 1 | Global block enable |
| tx_run | input | 1 | Playback direction running |
| rx_run | input | 1 | Capture direction running |
| dma_en | input | 1 | Gate for the DMA request and panic outputs |
| tx_need_sel | input | 2 | Playback need level in quarters of depth |
| rx_need_sel | input | 2 | Capture need level in quarters of depth |
| dma_levels | input | 32 | Levels: tx panic 31:24, rx panic 23:16, tx request 15:8, rx request 7:0 |
| irq_en | input | 4 | Interrupt enables, same bit order as irq_status |
| tx_clr | input | 1 | Playback flush pulse |
| rx_clr | input | 1 | Capture flush pulse |
| sync_tgl | input | 1 | Software handshake level |
| sync_echo | output | 1 | Handshake level returned through the bit-clock domain |
| err_clr_tx | input | 1 | Clear pulse for tx_err |
| err_clr_rx | input | 1 | Clear pulse for rx_err |
| host_wr | input | 1 | Host write strobe into the playback FIFO |
| host_wdata | input | 32 | Host write word |
| host_rd | input | 1 | Host read strobe from the capture FIFO |
| host_rdata | output | 32 | Capture FIFO head word |
| ser_tx_pop | input | 1 | Serializer pop from the playback FIFO |
| ser_tx_data | output | 32 | Playback FIFO head word |
| ser_rx_push | input | 1 | Serializer push into the capture FIFO |
| ser_rx_data | input | 32 | Serializer word to capture |
| tx_empty | output | 1 | Playback FIFO empty |
| rx_has_data | output | 1 | Capture FIFO not empty |
| rx_full | output | 1 | Capture FIFO full |
| tx_need | output | 1 | Playback needs writing |
| rx_need | output | 1 | Capture needs reading |
| tx_err | output | 1 | Sticky playback underflow |
| rx_err | output | 1 | Sticky capture overflow |
| dma_tx_req | output | 1 | Playback DMA request |
| dma_tx_panic | output | 1 | Playback DMA panic |
| dma_rx_req | output | 1 | Capture DMA request |
| dma_rx_panic | output | 1 | Capture DMA panic |
| irq_status | output | 4 | Masked interrupt sources |
| irq | output | 1 | Any enabled interrupt source |

## Verification
The fill levels are driven by random traffic on all four FIFO ports. The traffic runs under random levels, need selectors, enables and run bits. It is biased in turn towards filling and towards draining, so that both full and empty are reached. Under this traffic every level comparison flips both ways, which separates a strict from an inclusive comparison and a request field from its panic field. Directed runs cover the cases that random traffic cannot isolate. These are writes while disabled, serializer strobes while a direction is stopped, and flushes and handshake toggles with nothing else active. In those runs the early sample tells a flush or echo that waits for the bit clock apart from one that bypasses it.

// File: rtl/pcm_fifo_pkg.sv
package pcm_fifo_pkg;
    // interrupt vector bit positions
    localparam int IRQ_TXN = 0;
    localparam int IRQ_RXN = 1;
    localparam int IRQ_TXE = 2;
    localparam int IRQ_RXE = 3;
    localparam int ECHO_W  = 3;  // tx flush, rx flush, handshake

    typedef struct packed {
        logic       tx_tgl;
        logic       rx_tgl;
        logic [1:0] echo_prev;
        logic       tx_err;
        logic       rx_err;
    } ctl_state_t;
endpackage

// File: rtl/pcm_word_fifo.sv
module pcm_word_fifo #(
    parameter  int DW    = 32,
    parameter  int DEPTH = 64,   // power of two
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          clr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t s_d, s_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        do_push = push && !clr && (s_q.cnt != CW'(DEPTH));
        do_pop  = pop  && !clr && (s_q.cnt != '0);
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wp = s_q.wp + 1'b1;
            if (do_pop)  s_d.rp = s_q.rp + 1'b1;
            s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wp] <= wdata;
    end

    assign rdata = mem_q[s_q.rp];
    assign count = s_q.cnt;
endmodule

// File: rtl/pcm_bclk_echo.sv
module pcm_bclk_echo #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         bclk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] echo_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [1:0] b_q;
        logic [1:0] c_q;
        always_ff @(posedge bclk or negedge rst_n) begin
            if (!rst_n) b_q <= '0;
            else        b_q <= {b_q[0], src_i[i]};
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) c_q <= '0;
            else        c_q <= {c_q[0], b_q[1]};
        end
        assign echo_o[i] = c_q[1];
    end
endmodule

// File: rtl/pcm_fifo_dma.sv
module pcm_fifo_dma
    import pcm_fifo_pkg::*;
#(
    parameter  int DW    = 32,
    parameter  int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH) + 1,
    localparam int QTR   = DEPTH / 4
) (
    input  logic          clk,
    input  logic          bclk,
    input  logic          rst_n,
    input  logic          blk_en,
    input  logic          tx_run,
    input  logic          rx_run,
    input  logic          dma_en,
    input  logic [1:0]    tx_need_sel,
    input  logic [1:0]    rx_need_sel,
    input  logic [31:0]   dma_levels,
    input  logic [3:0]    irq_en,
    input  logic          tx_clr,
    input  logic          rx_clr,
    input  logic          sync_tgl,
    output logic          sync_echo,
    input  logic          err_clr_tx,
    input  logic          err_clr_rx,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    input  logic          ser_tx_pop,
    output logic [DW-1:0] ser_tx_data,
    input  logic          ser_rx_push,
    input  logic [DW-1:0] ser_rx_data,
    output logic          tx_empty,
    output logic          rx_has_data,
    output logic          rx_full,
    output logic          tx_need,
    output logic          rx_need,
    output logic          tx_err,
    output logic          rx_err,
    output logic          dma_tx_req,
    output logic          dma_tx_panic,
    output logic          dma_rx_req,
    output logic          dma_rx_panic,
    output logic [3:0]    irq_status,
    output logic          irq
);
    ctl_state_t s_d, s_q;
    logic [ECHO_W-1:0] echo;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic tx_clr_fire, rx_clr_fire, dma_gate;

    pcm_bclk_echo #(.N(ECHO_W)) u_echo (
        .clk(clk), .bclk(bclk), .rst_n(rst_n),
        .src_i({sync_tgl, s_q.rx_tgl, s_q.tx_tgl}),
        .echo_o(echo)
    );

    assign tx_clr_fire = echo[0] ^ s_q.echo_prev[0];
    assign rx_clr_fire = echo[1] ^ s_q.echo_prev[1];
    assign sync_echo   = echo[2];

    pcm_word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(blk_en && host_wr),
        .pop(blk_en && tx_run && ser_tx_pop),
        .clr(tx_clr_fire),
        .wdata(host_wdata), .rdata(ser_tx_data), .count(tx_cnt)
    );

    pcm_word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(blk_en && rx_run && ser_rx_push),
        .pop(blk_en && host_rd),
        .clr(rx_clr_fire),
        .wdata(ser_rx_data), .rdata(host_rdata), .count(rx_cnt)
    );

    always_comb begin
        s_d = s_q;
        s_d.echo_prev = echo[1:0];
        // a new flush is accepted only once the previous one has returned
        if (tx_clr && (s_q.tx_tgl == echo[0])) s_d.tx_tgl = ~s_q.tx_tgl;
        if (rx_clr && (s_q.rx_tgl == echo[1])) s_d.rx_tgl = ~s_q.rx_tgl;
        s_d.tx_err = (s_q.tx_err && !err_clr_tx) ||
                     (blk_en && tx_run && ser_tx_pop && (tx_cnt == '0));
        s_d.rx_err = (s_q.rx_err && !err_clr_rx) ||
                     (blk_en && rx_run && ser_rx_push && (rx_cnt == CW'(DEPTH)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tx_empty    = (tx_cnt == '0);
    assign rx_has_data = (rx_cnt != '0);
    assign rx_full     = (rx_cnt == CW'(DEPTH));
    assign tx_need     = int'(tx_cnt) <= int'(tx_need_sel) * QTR;
    assign rx_need     = int'(rx_cnt) >  int'(rx_need_sel) * QTR;
    assign tx_err      = s_q.tx_err;
    assign rx_err      = s_q.rx_err;

    assign dma_gate     = dma_en && blk_en;
    assign dma_tx_panic = dma_gate && (int'(tx_cnt) < int'(dma_levels[31:24]));
    assign dma_rx_panic = dma_gate && (int'(rx_cnt) > int'(dma_levels[23:16]));
    assign dma_tx_req   = dma_gate && (int'(tx_cnt) < int'(dma_levels[15:8]));
    assign dma_rx_req   = dma_gate && (int'(rx_cnt) > int'(dma_levels[7:0]));

    always_comb begin
        irq_status          = '0;
        irq_status[IRQ_TXN] = tx_need;
        irq_status[IRQ_RXN] = rx_need;
        irq_status[IRQ_TXE] = s_q.tx_err;
        irq_status[IRQ_RXE] = s_q.rx_err;
        irq_status          = irq_status & irq_en;
    end
    assign irq = |irq_status;
endmodule

// File: rtl/pcm_fifo_dma_chk.sv
module pcm_fifo_dma_chk #(
    parameter  int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          blk_en,
    input logic          dma_en,
    input logic          host_rd,
    input logic          err_clr_tx,
    input logic          err_clr_rx,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic          tx_clr_fire,
    input logic          rx_clr_fire,
    input logic          tx_empty,
    input logic          rx_full,
    input logic          tx_err,
    input logic          rx_err,
    input logic          dma_tx_req,
    input logic          dma_tx_panic,
    input logic          dma_rx_req,
    input logic          dma_rx_panic
);
    a_r2_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_cnt) <= DEPTH);
    a_r2_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rx_cnt) <= DEPTH);
    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && !host_rd && !rx_clr_fire |=> rx_full);
    a_r5_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_en && blk_en) |-> !(dma_tx_req || dma_tx_panic || dma_rx_req || dma_rx_panic));
    a_r9_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err && !err_clr_tx |=> tx_err);
    a_r9_rx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err && !err_clr_rx |=> rx_err);
    a_r11_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr_fire |=> tx_empty);
    a_r11_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr_fire |=> (rx_cnt == '0));
endmodule

bind pcm_fifo_dma pcm_fifo_dma_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .dma_en(dma_en),
    .host_rd(host_rd), .err_clr_tx(err_clr_tx), .err_clr_rx(err_clr_rx),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_clr_fire(tx_clr_fire), .rx_clr_fire(rx_clr_fire),
    .tx_empty(tx_empty), .rx_full(rx_full), .tx_err(tx_err), .rx_err(rx_err),
    .dma_tx_req(dma_tx_req), .dma_tx_panic(dma_tx_panic),
    .dma_rx_req(dma_rx_req), .dma_rx_panic(dma_rx_panic)
);

// File: tb/test_pcm_fifo_dma.sv
module test_pcm_fifo_dma;
    localparam int DEPTH = 64;
    localparam int QTR   = DEPTH / 4;

    logic clk = 0, bclk = 0, rst_n = 0;
    logic blk_en = 0, tx_run = 0, rx_run = 0, dma_en = 0;
    logic [1:0] tx_need_sel = 0, rx_need_sel = 0;
    logic [31:0] dma_levels = 0;
    logic [3:0] irq_en = 0;
    logic tx_clr = 0, rx_clr = 0, sync_tgl = 0, sync_echo;
    logic err_clr_tx = 0, err_clr_rx = 0;
    logic host_wr = 0, host_rd = 0, ser_tx_pop = 0, ser_rx_push = 0;
    logic [31:0] host_wdata = 0, ser_rx_data = 0, host_rdata, ser_tx_data;
    logic tx_empty, rx_has_data, rx_full, tx_need, rx_need, tx_err, rx_err;
    logic dma_tx_req, dma_tx_panic, dma_rx_req, dma_rx_panic, irq;
    logic [3:0] irq_status;

    int n_chk = 0, n_fail = 0;
    logic [31:0] mtx[$];
    logic [31:0] mrx[$];
    logic m_txerr = 0, m_rxerr = 0;

    always #4 clk = ~clk;
    initial begin #3; forever #32 bclk = ~bclk; end

    pcm_fifo_dma i_pcm_fifo_dma (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        int tc = mtx.size();
        int rc = mrx.size();
        logic g = dma_en && blk_en;
        logic [3:0] ist;
        chk("R8 tx_empty", tx_empty, tc == 0);
        chk("R8 rx_has_data", rx_has_data, rc != 0);
        chk("R8 rx_full", rx_full, rc == DEPTH);
        chk("R7 tx_need", tx_need, tc <= int'(tx_need_sel) * QTR);
        chk("R7 rx_need", rx_need, rc > int'(rx_need_sel) * QTR);
        chk("R5 dma_tx_req", dma_tx_req, g && tc < int'(dma_levels[15:8]));
        chk("R5 dma_tx_panic", dma_tx_panic, g && tc < int'(dma_levels[31:24]));
        chk("R6 dma_rx_req", dma_rx_req, g && rc > int'(dma_levels[7:0]));
        chk("R6 dma_rx_panic", dma_rx_panic, g && rc > int'(dma_levels[23:16]));
        chk("R9 tx_err", tx_err, m_txerr);
        chk("R9 rx_err", rx_err, m_rxerr);
        ist = {m_rxerr, m_txerr, rc > int'(rx_need_sel) * QTR,
               tc <= int'(tx_need_sel) * QTR} & irq_en;
        chk("R10 irq_status", irq_status, ist);
        chk("R10 irq", irq, |ist);
        if (tc != 0) chk("R2 tx head", ser_tx_data, mtx[0]);
        if (rc != 0) chk("R2 rx head", host_rdata, mrx[0]);
    endtask

    // effect of the currently driven inputs at the next rising edge
    task automatic model_step();
        int tc = mtx.size();
        int rc = mrx.size();
        logic tx_uf = blk_en && tx_run && ser_tx_pop && tc == 0;
        logic rx_of = blk_en && rx_run && ser_rx_push && rc == DEPTH;
        if (blk_en && tx_run && ser_tx_pop && tc > 0) void'(mtx.pop_front());
        if (blk_en && host_wr && tc < DEPTH) mtx.push_back(host_wdata);
        if (blk_en && host_rd && rc > 0) void'(mrx.pop_front());
        if (blk_en && rx_run && ser_rx_push && rc < DEPTH) mrx.push_back(ser_rx_data);
        m_txerr = (m_txerr && !err_clr_tx) || tx_uf;
        m_rxerr = (m_rxerr && !err_clr_rx) || rx_of;
    endtask

    task automatic idle();
        host_wr = 0; host_rd = 0; ser_tx_pop = 0; ser_rx_push = 0;
        err_clr_tx = 0; err_clr_rx = 0; tx_clr = 0; rx_clr = 0;
    endtask

    task automatic step();
        model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) begin
            idle();
            step();
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int bias;
        void'($urandom(32'h1234_5eed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_has_data", rx_has_data, 0);
        chk("R1 errors", {tx_err, rx_err}, 0);
        chk("R1 dma", {dma_tx_req, dma_tx_panic, dma_rx_req, dma_rx_panic}, 0);
        chk("R1 sync_echo", sync_echo, 0);

        // R3: disabled block ignores all traffic, DMA stays low
        dma_en = 1; dma_levels = 32'hFFFF_FFFF;
        host_wr = 1; host_wdata = 32'hDEAD_0001; tx_run = 1; rx_run = 1;
        ser_rx_push = 1; ser_rx_data = 32'hBEEF_0001;
        step();
        chk("R3 tx ignored", tx_empty, 1);
        chk("R3 rx ignored", rx_has_data, 0);
        chk("R3 dma low", {dma_tx_req, dma_tx_panic}, 0);

        // R4: stopped directions ignore serializer strobes
        blk_en = 1; tx_run = 0; rx_run = 0; ser_rx_push = 0;
        host_wr = 1; host_wdata = 32'hA5A5_0001;
        step();
        idle(); ser_tx_pop = 1; ser_rx_push = 1; ser_rx_data = 32'h1111_2222;
        step();
        chk("R4 tx pop ignored", ser_tx_data, 32'hA5A5_0001);
        chk("R4 no underflow err", tx_err, 0);
        chk("R4 rx push ignored", rx_has_data, 0);
        idle();

        // random traffic with fill and drain phases
        for (int blk = 0; blk < 40; blk++) begin
            dma_levels = {8'($urandom_range(0, 70)), 8'($urandom_range(0, 70)),
                          8'($urandom_range(0, 70)), 8'($urandom_range(0, 70))};
            tx_need_sel = 2'($urandom); rx_need_sel = 2'($urandom);
            irq_en = 4'($urandom);
            dma_en = ($urandom_range(0, 7) != 0);
            blk_en = ($urandom_range(0, 9) != 0);
            tx_run = ($urandom_range(0, 4) != 0);
            rx_run = ($urandom_range(0, 4) != 0);
            bias = blk % 3;
            for (int c = 0; c < 100; c++) begin
                host_wr     = ($urandom_range(0, 9) < (bias == 0 ? 8 : (bias == 1 ? 2 : 5)));
                ser_tx_pop  = ($urandom_range(0, 9) < (bias == 0 ? 2 : (bias == 1 ? 8 : 5)));
                ser_rx_push = ($urandom_range(0, 9) < (bias == 0 ? 8 : (bias == 1 ? 2 : 5)));
                host_rd     = ($urandom_range(0, 9) < (bias == 0 ? 2 : (bias == 1 ? 8 : 5)));
                host_wdata  = $urandom;
                ser_rx_data = $urandom;
                err_clr_tx  = ($urandom_range(0, 30) == 0);
                err_clr_rx  = ($urandom_range(0, 30) == 0);
                step();
            end
        end
        idle();

        // R11 playback flush waits for the bit clock
        blk_en = 1; tx_run = 1; rx_run = 1;
        for (int i = 0; i < 5; i++) begin
            host_wr = 1; host_wdata = 32'hC0DE_0000 + i;
            step();
        end
        idle(); tx_clr = 1;
        model_step();
        @(negedge clk); tx_clr = 0;
        @(negedge clk); @(negedge clk);
        chk("R11 tx not yet flushed", tx_empty, (mtx.size() == 0));
        repeat (40) @(negedge clk);
        mtx.delete();
        chk("R11 tx flushed", tx_empty, 1);

        // R11 capture flush
        for (int i = 0; i < 4; i++) begin
            ser_rx_push = 1; ser_rx_data = 32'hFACE_0000 + i;
            step();
        end
        idle(); rx_clr = 1;
        model_step();
        @(negedge clk); rx_clr = 0;
        @(negedge clk); @(negedge clk);
        chk("R11 rx not yet flushed", rx_has_data, (mrx.size() != 0));
        repeat (40) @(negedge clk);
        mrx.delete();
        chk("R11 rx flushed", rx_has_data, 0);
        check_all();

        // R12 handshake echo through the bit-clock domain
        sync_tgl = 1;
        repeat (3) @(negedge clk);
        chk("R12 echo not early", sync_echo, 0);
        repeat (40) @(negedge clk);
        chk("R12 echo high", sync_echo, 1);
        sync_tgl = 0;
        repeat (3) @(negedge clk);
        chk("R12 echo holds", sync_echo, 1);
        repeat (40) @(negedge clk);
        chk("R12 echo low", sync_echo, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule